// File: doc/BRIEF.md
# Single-Cycle Ten-Instruction Processor Core

This block is a 32-bit processor that finishes one instruction on every rising clock edge. An instruction is fetched from the address held in the program counter. It is then decoded, and its operands are read from a 32-entry register file. The ALU and the data memory access both complete combinationally, and the result is committed at the next edge. The core covers register arithmetic and logic (add, sub, and, or, set-on-less-than), add-immediate, word load and store, branch-on-equal and an absolute jump within the current 256 MB region.

Decoding is split into two stages. A main decoder sees only the 6-bit opcode. It produces the datapath steering bits and a 2-bit ALU class. A second decoder turns that class, together with the 6-bit function field, into a 3-bit ALU operation.

The top level wraps the core together with a word-addressed instruction array and a word-addressed data array. A side port lets the environment fill both arrays while the core is held in reset. Every committed instruction is reported on registered retire outputs. These give its address, the register it wrote and the store it made, so an outside model can follow execution cycle by cycle.

Top module: `scx_sys`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, and the edge writes neither a register nor the data array. After that edge `ret_rf_we` and `ret_st_we` are low.
- R2: Opcode 0 with function code 32, 34, 36, 37 or 42 writes add, subtract, bitwise AND, bitwise OR or signed less-than (result 1 or 0) of registers rs (bits 25:21) and rt (bits 20:16) into register rd (bits 15:11). The PC then advances by 4.
- R3: Opcode 8 writes rs plus the sign-extended immediate (bits 15:0) into register rt.
- R4: Opcode 35 writes into rt the data word at byte address rs + sign-extended immediate. The word index is address bits [ADDR_W+1:2].
- R5: Opcode 43 stores register rt at byte address rs + sign-extended immediate and writes no register.
- R6: Opcode 4 sets the next PC to PC+4 + (sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise. It writes nothing.
- R7: Opcode 2 sets the next PC to {PC+4 bits 31:28, target bits 25:0, 2'b00} and writes nothing.
- R8: Register 0 always reads as zero. A write aimed at it changes nothing and is not reported on `ret_rf_we`.
- R9: Any other opcode writes nothing and only advances the PC by 4.
- R10: After each edge with `rst` low, `ret_pc` shows the address of the instruction committed at that edge. `ret_rf_we`/`ret_rf_idx`/`ret_rf_data` show its register write, and `ret_st_we`/`ret_st_addr`/`ret_st_data` show its store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one word into an array this edge |
| load_dmem | input | 1 | Load target: 0 instruction array, 1 data array |
| load_addr | input | ADDR_W | Word index of the loaded word |
| load_data | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| ret_pc | output | 32 | Address of the instruction committed at the last edge |
| ret_rf_we | output | 1 | Last committed instruction changed a register |
| ret_rf_idx | output | 5 | Register it wrote |
| ret_rf_data | output | 32 | Value it wrote |
| ret_st_we | output | 1 | Last committed instruction stored a word |
| ret_st_addr | output | 32 | Byte address of that store |
| ret_st_data | output | 32 | Stored word |

## Verification
The bench drives a short program covering the following cases, and an independent behavioural model checks every cycle:
- A negative immediate. A wrong sign extension would give large positive sums.
- A signed less-than in both directions. An unsigned compare would report -3 < 5 as false.
- A load whose address comes from a negative offset.
- A store followed by a load-back of the same word.
- A write aimed at register 0 and later read back. A core that let the write land would return 7 instead of 0.
- A branch-on-equal both not taken and taken. A target adder that used PC instead of PC+4, or skipped the shift by 2, would land on a skipped instruction.
- An unlisted opcode, which must be a silent step.
- Two jumps, one of them a jump to itself that must hold the PC steady.

// File: rtl/scx_pkg.sv
package scx_pkg;

  localparam int XW = 32;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_LW    = 6'd35;
  localparam logic [5:0] OPC_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    AC_ADD   = 2'b00,
    AC_SUB   = 2'b01,
    AC_FUNCT = 2'b10
  } alu_class_e;

  typedef enum logic [2:0] {
    AF_AND = 3'b000,
    AF_OR  = 3'b001,
    AF_ADD = 3'b010,
    AF_SUB = 3'b110,
    AF_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic       dst_rd;
    logic       src_imm;
    logic       wb_mem;
    logic       rf_we;
    logic       mem_rd;
    logic       mem_we;
    logic       branch;
    logic       jump;
    alu_class_e aclass;
  } ctrl_t;

endpackage

// File: rtl/scx_main_dec.sv
module scx_main_dec
  import scx_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{default: '0, aclass: AC_ADD};
    case (opcode)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.aclass = AC_FUNCT;
      end
      OPC_ADDI: begin
        ctl.src_imm = 1'b1;
        ctl.rf_we   = 1'b1;
      end
      OPC_LW: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.rf_we   = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OPC_SW: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.aclass = AC_SUB;
      end
      OPC_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scx_alu_dec.sv
module scx_alu_dec
  import scx_pkg::*;
(
  input  alu_class_e aclass,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    case (aclass)
      AC_SUB:   fn = AF_SUB;
      AC_FUNCT: begin
        case (funct)
          FN_SUB:  fn = AF_SUB;
          FN_AND:  fn = AF_AND;
          FN_OR:   fn = AF_OR;
          FN_SLT:  fn = AF_SLT;
          default: fn = AF_ADD;
        endcase
      end
      default:  fn = AF_ADD;
    endcase
  end
endmodule

// File: rtl/scx_alu.sv
module scx_alu
  import scx_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e        fn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           zero
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    case (fn)
      AF_AND:  y = a & b;
      AF_OR:   y = a | b;
      AF_SUB:  y = diff;
      AF_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/scx_regfile.sv
module scx_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && $past(wa) != '0) |-> regs[$past(wa)] == $past(wd)); // R2
endmodule

// File: rtl/scx_core.sv
module scx_core
  import scx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREG   = 32,
  localparam int RW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XW-1:0]     imem_addr,
  input  logic [XW-1:0]     instr,
  output logic [XW-1:0]     dmem_addr,
  output logic              dmem_we,
  output logic [XW-1:0]     dmem_wdata,
  input  logic [XW-1:0]     dmem_rdata,
  output logic [XW-1:0]     pc_o,
  output logic [XW-1:0]     ret_pc,
  output logic              ret_rf_we,
  output logic [RW-1:0]     ret_rf_idx,
  output logic [XW-1:0]     ret_rf_data,
  output logic              ret_st_we,
  output logic [XW-1:0]     ret_st_addr,
  output logic [XW-1:0]     ret_st_data
);
  logic [XW-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target, imm_sx;
  logic [XW-1:0] rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [RW-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic          alu_zero, take_br, rf_commit;
  ctrl_t         ctl;
  alu_fn_e       fn;

  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  scx_main_dec u_main (.opcode(instr[31:26]), .ctl(ctl));
  scx_alu_dec  u_adec (.aclass(ctl.aclass), .funct(instr[5:0]), .fn(fn));

  scx_regfile #(.W(XW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(rs_idx), .ra2(rt_idx), .rd1(rs_val), .rd2(rt_val),
    .we(rf_commit), .wa(dst_idx), .wd(wb_val)
  );

  assign alu_b = ctl.src_imm ? imm_sx : rt_val;

  scx_alu #(.W(XW)) u_alu (.fn(fn), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign dst_idx   = ctl.dst_rd ? rd_idx : rt_idx;
  assign wb_val    = ctl.wb_mem ? dmem_rdata : alu_y;
  assign rf_commit = ctl.rf_we && !rst;

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_we    = ctl.mem_we && !rst;
  assign dmem_wdata = rt_val;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XW-3:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br    = ctl.branch && alu_zero;

  always_comb begin
    if (ctl.jump)     pc_next = jmp_target;
    else if (take_br) pc_next = br_target;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= '0;
      ret_pc      <= '0;
      ret_rf_we   <= 1'b0;
      ret_rf_idx  <= '0;
      ret_rf_data <= '0;
      ret_st_we   <= 1'b0;
      ret_st_addr <= '0;
      ret_st_data <= '0;
    end else begin
      pc_q        <= pc_next;
      ret_pc      <= pc_q;
      ret_rf_we   <= ctl.rf_we && (dst_idx != '0);
      ret_rf_idx  <= dst_idx;
      ret_rf_data <= wb_val;
      ret_st_we   <= ctl.mem_we;
      ret_st_addr <= alu_y;
      ret_st_data <= rt_val;
    end
  end

  assign pc_o = pc_q;

  logic unused_core;
  assign unused_core = ^{instr[10:6], ctl.mem_rd};

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctl.branch) && !$past(ctl.jump)) |-> pc_q == $past(pc_q) + 32'd4); // R9
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl.jump)) |-> (pc_q[31:28] == $past(pc_plus4[31:28]) && pc_q[1:0] == 2'b00)); // R7
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl.branch) && $past(rs_val) == $past(rt_val))
      |-> pc_q == $past(pc_q) + 32'd4 + {$past(imm_sx[XW-3:0]), 2'b00}); // R6
  AST_BEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl.branch) && $past(rs_val) != $past(rt_val)) |-> pc_q == $past(pc_q) + 32'd4); // R6
  AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> instr[31:26] == OPC_SW); // R5
endmodule

// File: rtl/scx_sys.sv
module scx_sys
  import scx_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              load_dmem,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [31:0]       load_data,
  output logic [31:0]       pc_o,
  output logic [31:0]       ret_pc,
  output logic              ret_rf_we,
  output logic [4:0]        ret_rf_idx,
  output logic [31:0]       ret_rf_data,
  output logic              ret_st_we,
  output logic [31:0]       ret_st_addr,
  output logic [31:0]       ret_st_data
);
  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] imem_addr, instr, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [ADDR_W-1:0] iidx, didx;

  assign iidx = imem_addr[ADDR_W+1:2];
  assign didx = dmem_addr[ADDR_W+1:2];

  always_ff @(posedge clk) begin
    if (load_en && !load_dmem) imem[load_addr] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_en && load_dmem) dmem[load_addr] <= load_data;
    else if (dmem_we)         dmem[didx]      <= dmem_wdata;
  end

  assign instr      = imem[iidx];
  assign dmem_rdata = dmem[didx];

  scx_core #(.ADDR_W(ADDR_W), .NREG(32)) u_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .instr(instr),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .pc_o(pc_o), .ret_pc(ret_pc),
    .ret_rf_we(ret_rf_we), .ret_rf_idx(ret_rf_idx), .ret_rf_data(ret_rf_data),
    .ret_st_we(ret_st_we), .ret_st_addr(ret_st_addr), .ret_st_data(ret_st_data)
  );

  logic unused_sys;
  assign unused_sys = ^{imem_addr[31:ADDR_W+2], imem_addr[1:0], dmem_addr[31:ADDR_W+2], dmem_addr[1:0]};
endmodule

// File: tb/scx_sys_tb_top.sv
`timescale 1ns/1ps
module scx_sys_tb_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0, load_dmem = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, ret_pc, ret_rf_data, ret_st_addr, ret_st_data;
  logic [4:0]  ret_rf_idx;
  logic        ret_rf_we, ret_st_we;

  always #10 clk = ~clk;

  scx_sys #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .pc_o(pc_o), .ret_pc(ret_pc), .ret_rf_we(ret_rf_we), .ret_rf_idx(ret_rf_idx),
    .ret_rf_data(ret_rf_data), .ret_st_we(ret_st_we), .ret_st_addr(ret_st_addr),
    .ret_st_data(ret_st_data)
  );

  int total = 0, fails = 0;
  bit finished = 0;

  logic [31:0] mim [DEPTH];
  logic [31:0] mdm [DEPTH];
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  logic [31:0] e_pc, e_ret_pc, e_rf_data, e_st_addr, e_st_data;
  logic [4:0]  e_rf_idx;
  logic        e_rf_we, e_st_we;
  string       tag;

  function automatic logic [31:0] enc_r(int fn, int rd, int rs, int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, tgt[25:0]};
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic load_word(bit sel, int idx, logic [31:0] w);
    @(negedge clk);
    load_en = 1'b1; load_dmem = sel; load_addr = idx[AW-1:0]; load_data = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Behavioural model: one instruction per call, producing the expectations for the next edge.
  task automatic model_step();
    logic [31:0] ins, a, b, sx, v, addr, npc;
    int op, rs, rt, rd, fn, dest;
    bit wr;
    ins = mim[mpc[AW+1:2]];
    op = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
    rd = int'(ins[15:11]); fn = int'(ins[5:0]);
    a = mreg[rs]; b = mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = mpc + 4; wr = 0; dest = 0; v = 0;
    e_ret_pc = mpc; e_rf_we = 0; e_st_we = 0; tag = "R9";
    case (op)
      0: begin
        tag = "R2"; wr = 1; dest = rd;
        case (fn)
          34: v = a - b;
          36: v = a & b;
          37: v = a | b;
          42: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: v = a + b;
        endcase
      end
      8:  begin tag = "R3"; wr = 1; dest = rt; v = a + sx; end
      35: begin tag = "R4"; wr = 1; dest = rt; addr = a + sx; v = mdm[addr[AW+1:2]]; end
      43: begin
        tag = "R5"; addr = a + sx;
        e_st_we = 1; e_st_addr = addr; e_st_data = b;
        mdm[addr[AW+1:2]] = b;
      end
      4:  begin tag = "R6"; if (a == b) npc = mpc + 4 + (sx << 2); end
      2:  begin tag = "R7"; npc = {npc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (wr && dest == 0) tag = "R8";
    if (wr && dest != 0) begin
      mreg[dest] = v;
      e_rf_we = 1; e_rf_idx = dest[4:0]; e_rf_data = v;
    end
    mpc = npc;
    e_pc = npc;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] prog [22];
    prog[0]  = enc_i(8, 1, 0, 5);        // R3 addi r1 = 5
    prog[1]  = enc_i(8, 2, 0, -3);       // R3 negative immediate
    prog[2]  = enc_r(32, 3, 1, 2);       // R2 add
    prog[3]  = enc_r(34, 4, 1, 2);       // R2 sub
    prog[4]  = enc_r(36, 5, 1, 2);       // R2 and
    prog[5]  = enc_r(37, 6, 1, 2);       // R2 or
    prog[6]  = enc_r(42, 7, 2, 1);       // R2 slt true (signed)
    prog[7]  = enc_r(42, 8, 1, 2);       // R2 slt false
    prog[8]  = enc_i(43, 4, 0, 8);       // R5 store r4 to byte 8
    prog[9]  = enc_i(35, 9, 0, 8);       // R4 load it back
    prog[10] = enc_i(35, 10, 4, -4);     // R4 negative offset -> word 1
    prog[11] = enc_i(8, 0, 0, 7);        // R8 write to r0
    prog[12] = enc_r(32, 11, 0, 0);      // R8 read r0
    prog[13] = enc_i(4, 2, 1, 5);        // R6 not taken
    prog[14] = enc_i(4, 3, 3, 2);        // R6 taken -> 68
    prog[15] = enc_i(8, 12, 0, 99);      // skipped
    prog[16] = enc_i(8, 12, 0, 77);      // skipped
    prog[17] = 32'hFC00_0000;            // R9 unknown opcode
    prog[18] = enc_j(20);                // R7 jump to 80
    prog[19] = enc_i(8, 13, 0, 1);       // skipped
    prog[20] = enc_r(34, 14, 2, 1);      // R2 sub -> -8
    prog[21] = enc_j(21);                // R7 jump to self

    for (int i = 0; i < DEPTH; i++) begin mim[i] = '0; mdm[i] = '0; end
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int i = 0; i < 22; i++) mim[i] = prog[i];
    mdm[1] = 32'h1234_5678;

    for (int i = 0; i < DEPTH; i++) load_word(1'b0, i, mim[i]);
    for (int i = 0; i < DEPTH; i++) load_word(1'b1, i, mdm[i]);

    @(negedge clk);
    chk("R1 pc after reset", pc_o, 32'd0);
    chk("R1 rf strobe in reset", {31'd0, ret_rf_we}, 32'd0);
    chk("R1 store strobe in reset", {31'd0, ret_st_we}, 32'd0);
    rst = 1'b0;
    mpc = 32'd0;

    for (int c = 0; c < 30; c++) begin
      model_step();
      @(negedge clk);
      chk({tag, " next pc"}, pc_o, e_pc);
      chk({"R10 retire pc (", tag, ")"}, ret_pc, e_ret_pc);
      chk({tag, " register write strobe"}, {31'd0, ret_rf_we}, {31'd0, e_rf_we});
      if (e_rf_we) begin
        chk({tag, " register index"}, {27'd0, ret_rf_idx}, {27'd0, e_rf_idx});
        chk({tag, " register data"}, ret_rf_data, e_rf_data);
      end
      chk({tag, " store strobe"}, {31'd0, ret_st_we}, {31'd0, e_st_we});
      if (e_st_we) begin
        chk({tag, " store address"}, ret_st_addr, e_st_addr);
        chk({tag, " store data"}, ret_st_data, e_st_data);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule